// File: doc/BRIEF.md
# Interrupt Priority Level Filter

This block sits between a set of level-sensitive interrupt request lines and a processor's trap sequencer. Each request line stands for one priority level, numbered 1 up to the highest; level 0 has no line and means "no interrupt". Software programs a processor interrupt level (the threshold) through a small write port. A pending request is accepted only when its level is strictly above that threshold and the global interrupt enable input is high.

When one or more lines qualify, the block raises a registered trap request and reports the highest qualifying level with it. The request stays up while the condition holds, until the sequencer acknowledges it. Dropping the enable, raising the threshold or removing the line takes the request away on the next cycle. Trap entry, state saving and vector fetch are the sequencer's job and are not part of this block.

Top module: `irqPilFilter`

## Requirements
- R1: After reset `trapReq` is 0, `trapLevel` is 0, and the threshold is 15 (all levels masked), so requests on every line with enable high give no trap until software lowers the threshold.
- R2: With the enable high, a request on line bit `k-1` (level `k`) whose level is strictly greater than the threshold sampled in cycle t raises `trapReq` with `trapLevel` = `k` after the clock edge ending cycle t.
- R3: A request whose level is less than or equal to the threshold is ignored: `trapReq` stays 0.
- R4: A threshold of 0 accepts every level from 1 to 15.
- R5: A threshold of 15 masks every level: `trapReq` is 0 in the cycle after the threshold reads 15.
- R6: While `intEnable` is 0 no trap request is produced; a request that is up falls in the cycle after the enable drops.
- R7: Among the pending levels above the threshold, `trapLevel` reports the highest-numbered one.
- R8: A threshold write (`pilWrEn` high with `pilWrData`) takes effect for the compare starting the cycle after the write edge; the cycle carrying the write still compares against the old value.
- R9: `trapAck` high while `trapReq` is high clears `trapReq` in the next cycle; `trapAck` while `trapReq` is low has no effect.
- R10: `trapLevel` is 0 whenever `trapReq` is 0.
- R11: When the accepting condition goes away (line released or threshold raised), `trapReq` falls in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_LEVELS-1 | Request lines; bit k-1 requests level k |
| pilWrEn | input | 1 | Threshold write strobe |
| pilWrData | input | LVL_W | New threshold value |
| intEnable | input | 1 | Global interrupt enable |
| trapAck | input | 1 | Acknowledge from the trap sequencer |
| trapReq | output | 1 | Registered trap request |
| trapLevel | output | LVL_W | Level of the presented request, 0 when idle |

## Verification
The bench builds the block with its default of sixteen levels, which gives fifteen request lines and a four-bit threshold. That brings both extreme thresholds, 0 and 15, within reach, as well as the topmost line and the equal-to-threshold boundary at every level. Random line patterns combined with random threshold writes also exercise the one-cycle delay of a write against requests that sit between the old and the new threshold.

// File: rtl/irqPilPkg.sv
package irqPilPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic pilLoad;     // capture a new threshold
    logic levelLoad;   // capture the winning level
    logic levelClear;  // return the level output to 0
  } ctrlStrobes_t;
endpackage

// File: rtl/irqPilDatapath.sv
module irqPilDatapath
  import irqPilPkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int PIL_RESET  = NUM_LEVELS - 1,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:1] irqReq,
  input  logic [LVL_W-1:0]      pilWrData,
  input  logic                  intEnable,
  input  ctrlStrobes_t          strobes,
  output logic                  qualify,
  output logic [LVL_W-1:0]      pilCur,
  output logic [LVL_W-1:0]      trapLevel
);
  logic [NUM_LEVELS-1:1] aboveVec;
  logic [LVL_W-1:0]      bestLevel;

  // Threshold register: the new value is used from the next cycle on
  always_ff @(posedge clk) begin
    if (!rstN)                pilCur <= LVL_W'(PIL_RESET);
    else if (strobes.pilLoad) pilCur <= pilWrData;
  end

  // Per-level strict compare against the threshold
  for (genvar g = 1; g < NUM_LEVELS; g++) begin : gAbove
    assign aboveVec[g] = irqReq[g] && (LVL_W'(g) > pilCur);
  end

  // Highest set position wins
  always_comb begin
    bestLevel = '0;
    for (int i = 1; i < NUM_LEVELS; i++) begin
      if (aboveVec[i]) bestLevel = LVL_W'(i);
    end
  end

  assign qualify = intEnable && (|aboveVec);

  always_ff @(posedge clk) begin
    if (!rstN)                   trapLevel <= '0;
    else if (strobes.levelLoad)  trapLevel <= bestLevel;
    else if (strobes.levelClear) trapLevel <= '0;
  end
endmodule

// File: rtl/irqPilControl.sv
module irqPilControl
  import irqPilPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         qualify,
  input  logic         pilWrEn,
  input  logic         trapAck,
  output ctrlStrobes_t strobes,
  output logic         trapReq
);
  logic reqNext;

  // An acknowledge only counts while the request is up
  assign reqNext = qualify && !(trapReq && trapAck);

  always_comb begin
    strobes.pilLoad    = pilWrEn;
    strobes.levelLoad  = reqNext;
    strobes.levelClear = !reqNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) trapReq <= 1'b0;
    else       trapReq <= reqNext;
  end
endmodule

// File: rtl/irqPilFilter.sv
module irqPilFilter
  import irqPilPkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int PIL_RESET  = NUM_LEVELS - 1,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-2:0] irqReq,
  input  logic                  pilWrEn,
  input  logic [LVL_W-1:0]      pilWrData,
  input  logic                  intEnable,
  input  logic                  trapAck,
  output logic                  trapReq,
  output logic [LVL_W-1:0]      trapLevel
);
  ctrlStrobes_t          strobes;
  logic                  qualify;
  logic [LVL_W-1:0]      pilCur;
  logic [NUM_LEVELS-1:1] irqByLevel;

  assign irqByLevel = irqReq;

  irqPilDatapath #(.NUM_LEVELS(NUM_LEVELS), .PIL_RESET(PIL_RESET)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqReq    (irqByLevel),
    .pilWrData (pilWrData),
    .intEnable (intEnable),
    .strobes   (strobes),
    .qualify   (qualify),
    .pilCur    (pilCur),
    .trapLevel (trapLevel)
  );

  irqPilControl ctl (
    .clk     (clk),
    .rstN    (rstN),
    .qualify (qualify),
    .pilWrEn (pilWrEn),
    .trapAck (trapAck),
    .strobes (strobes),
    .trapReq (trapReq)
  );
endmodule

// File: rtl/irqPilFilterChecker.sv
module irqPilFilterChecker #(
  parameter int NUM_LEVELS = 16,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_LEVELS-2:0] irqReq,
  input logic                  pilWrEn,
  input logic [LVL_W-1:0]      pilWrData,
  input logic                  intEnable,
  input logic                  trapAck,
  input logic                  trapReq,
  input logic [LVL_W-1:0]      trapLevel,
  input logic [LVL_W-1:0]      pilCur
);
  assert_idle_level_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |-> trapLevel == '0);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && trapAck) |=> !trapReq);

  assert_disable_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |=> !trapReq);

  assert_full_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pilCur == LVL_W'(NUM_LEVELS - 1)) |=> !trapReq);

  assert_write_next_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    pilWrEn |=> pilCur == $past(pilWrData));

  // The presented level was pending and nothing above it was
  assert_highest_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> ({$past(irqReq), 1'b0} >> trapLevel) == NUM_LEVELS'(1));

  assert_above_threshold_R2: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> trapLevel > $past(pilCur));
endmodule

bind irqPilFilter irqPilFilterChecker #(.NUM_LEVELS(NUM_LEVELS)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqReq    (irqReq),
  .pilWrEn   (pilWrEn),
  .pilWrData (pilWrData),
  .intEnable (intEnable),
  .trapAck   (trapAck),
  .trapReq   (trapReq),
  .trapLevel (trapLevel),
  .pilCur    (pilCur)
);

// File: tb/irqPilFilter_test.sv
`timescale 1ns/1ps
module irqPilFilter_test;
  localparam int NUM_LEVELS = 16;
  localparam int LVL_W      = $clog2(NUM_LEVELS);
  localparam int NL         = NUM_LEVELS - 1;

  logic             clk = 1'b0;
  logic             rstN;
  logic [NL-1:0]    irqReq;
  logic             pilWrEn;
  logic [LVL_W-1:0] pilWrData;
  logic             intEnable;
  logic             trapAck;
  logic             trapReq;
  logic [LVL_W-1:0] trapLevel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model state
  int modelPil;
  bit expReq;
  int expLvl;

  always #10 clk = ~clk;

  irqPilFilter #(.NUM_LEVELS(NUM_LEVELS)) uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .pilWrEn(pilWrEn),
    .pilWrData(pilWrData), .intEnable(intEnable), .trapAck(trapAck),
    .trapReq(trapReq), .trapLevel(trapLevel)
  );

  function automatic int highestAbove(logic [NL-1:0] lines, int pil);
    int best = 0;
    for (int k = 1; k <= NL; k++)
      if (lines[k-1] && k > pil) best = k;
    return best;
  endfunction

  task automatic checkOut(string tag);
    checks++;
    if (trapReq !== expReq || int'(trapLevel) != expLvl) begin
      fails++;
      $display("FAIL %s: actual req=%0b lvl=%0d expected req=%0b lvl=%0d",
               tag, trapReq, trapLevel, expReq, expLvl);
    end
  endtask

  // Drive one cycle of inputs at negedge, model the edge, check at next negedge
  task automatic step(logic [NL-1:0] lines, bit ie, bit ack, bit wr,
                      int wdata, string tag);
    int best;
    bit q;
    irqReq = lines; intEnable = ie; trapAck = ack;
    pilWrEn = wr; pilWrData = LVL_W'(wdata);
    @(posedge clk);
    best = highestAbove(lines, modelPil);
    q = ie && (best != 0);
    expReq = q && !(expReq && ack);
    expLvl = expReq ? best : 0;
    if (wr) modelPil = wdata;
    @(negedge clk);
    checkOut(tag);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    rstN = 1'b0; irqReq = '0; pilWrEn = 0; pilWrData = '0;
    intEnable = 0; trapAck = 0;
    modelPil = NL; expReq = 0; expLvl = 0;
    repeat (3) @(negedge clk);
    checkOut("R1 reset");
    rstN = 1'b1;
    // R1: threshold 15 after reset masks everything
    step('1, 1, 0, 0, 0, "R1 reset threshold");
    step('1, 1, 0, 0, 0, "R1 reset threshold");
    // R8: write 0 together with level 3; old threshold still used this cycle
    step(NL'(1) << 2, 1, 0, 1, 0, "R8 write cycle uses old");
    step(NL'(1) << 2, 1, 0, 0, 0, "R8 new threshold active");
    // R4: every level alone with threshold 0
    for (int k = 1; k <= NL; k++)
      step(NL'(1) << (k-1), 1, 0, 0, 0, "R4 threshold zero");
    // R3 / R2: boundary at threshold 7
    step('0, 1, 0, 1, 7, "R11 release");
    step(NL'(1) << 6, 1, 0, 0, 0, "R3 equal ignored");
    step(NL'(1) << 5, 1, 0, 0, 0, "R3 below ignored");
    step(NL'(1) << 7, 1, 0, 0, 0, "R2 above accepted");
    // R7: several pending
    step(NL'(15'b000_0101_0010_1000), 1, 0, 0, 0, "R7 highest");
    step(NL'(15'b100_0000_0000_0001), 1, 0, 0, 0, "R7 highest top");
    // R6: enable low
    step('1, 0, 0, 0, 0, "R6 enable low");
    step('1, 1, 0, 0, 0, "R6 enable back");
    // R9: ack while up, then re-raise
    step('1, 1, 1, 0, 0, "R9 ack clears");
    step('1, 1, 0, 0, 0, "R9 re-raise");
    step('0, 1, 1, 0, 0, "R11 release");
    step(NL'(1) << 9, 1, 1, 0, 0, "R9 ack while idle ignored");
    // R11 / R5: raise threshold to 15
    step(NL'(1) << 9, 1, 0, 1, 15, "R8 write 15 cycle");
    step(NL'(1) << 9, 1, 0, 0, 0, "R5 full mask");
    step('1, 1, 0, 0, 0, "R5 full mask all lines");
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [NL-1:0] lines;
      lines = NL'($urandom) & NL'($urandom);
      step(lines, ($urandom % 5) != 0, ($urandom % 3) == 0,
           ($urandom % 8) == 0, int'($urandom % NUM_LEVELS), "R7 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule